// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Enable Logic

This block keeps the interrupt side of a real-time clock: a status byte with three event flags and a summary flag, a control byte holding the matching enable bits, and a fixed status byte that reports valid RAM and time. Separate one-cycle pulses report a periodic tick, an alarm match and the end of a time update. Each pulse latches its flag whether or not it is enabled. The single level-sensitive interrupt output rises only when a flag that was clear becomes set while its enable is on.

Software reaches the three bytes through one access port. A read of the status byte returns its value and clears it at once, which acknowledges the interrupt. A write to the control byte re-evaluates the interrupt against the flags already pending. An enable that meets a pending flag raises the line straight away. If no enable meets a pending flag, the line drops. The timing sources, the time counters and the address decoder sit outside the block.

Top module: `rtc_irq_ctl`

## Requirements
- R1: The status byte (acc_sel=1) holds the periodic flag at bit 6, the alarm flag at bit 5 and the update-ended flag at bit 4, with the summary flag at bit 7 and bits 3:0 reading 0. A pulse on evt_per, evt_alm or evt_upd sets its flag on the next clock edge even when its enable is off.
- R2: The summary flag and irq are set on the edge after a pulse only when that pulse's flag was clear and its enable is set in the control byte (bit 6 periodic, bit 5 alarm, bit 4 update-ended). A pulse on a flag that is already set does not raise irq.
- R3: A read of the status byte returns its value in the same cycle (acc_rdata, combinational), clears the byte to 0x00 on the next edge and lowers irq.
- R4: When an event pulse arrives in the cycle of a status read, its flag is set after the clear. The summary flag and irq are also set if that event's enable is on.
- R5: A write to the control byte (acc_sel=0) sets the summary flag and irq on the next edge if any written enable bit 6:4 matches a set flag, counting events of that cycle. Otherwise it clears the summary flag and lowers irq.
- R6: Writes to the status byte (acc_sel=1) and to the fixed byte (acc_sel=2) change nothing. The fixed byte always reads 0x80.
- R7: Reset clears control bits 6, 5 and 3 and keeps the other control bits. It clears all status flags and holds irq low.
- R8: irq is a registered copy of status bit 7. It stays high until a status read or a control write that removes all matching enables.
- R9: The control byte reads back the last written value. Select 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_per | input | 1 | Periodic tick pulse |
| evt_alm | input | 1 | Alarm match pulse |
| evt_upd | input | 1 | Update-ended pulse |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 control, 1 status, 2 fixed, 3 unused |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences pull apart the four ways the summary flag can change: an event with its enable off, an event with its enable on, a control write that meets a pending flag, and a status read. A status read in the same cycle as an event shows whether the clear or the new flag wins. A reset with every control bit set shows which control bits reset clears. A long random run with a fixed seed mixes events, reads and writes at every select. Those orderings show whether an event on a flag that is already set raises irq again, and whether a stale summary flag survives a write that removes all matching enables.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } acc_sel_e;

   localparam int SRC_N    = 3;
   localparam int FLAG_LSB = 4;
   localparam int SUM_BIT  = 7;
endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg #(
   parameter int             DATA_W   = 8,
   parameter logic [DATA_W-1:0] CLR_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (CLR_MASK[i]) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)  q[i] <= 1'b0;
            else if (wr) q[i] <= wdata[i];
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (rst_n && wr) q[i] <= wdata[i];
         end
      end
   end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
   parameter int SRC_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] ev,
   input  logic             clr,
   input  logic             reeval,
   input  logic [SRC_N-1:0] en_now,
   output logic [SRC_N-1:0] flags,
   output logic             sum
);
   logic [SRC_N-1:0] base, fresh, flags_nx;
   logic             sum_nx;

   always_comb begin
      base     = clr ? '0 : flags;
      fresh    = ev & ~base;
      flags_nx = base | ev;
      if (reeval) sum_nx = |(en_now & flags_nx);
      else        sum_nx = (sum & ~clr) | (|(fresh & en_now));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         sum   <= 1'b0;
      end else begin
         flags <= flags_nx;
         sum   <= sum_nx;
      end
   end
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] STAT_V  = '0
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] ctl,
   input  logic [DATA_W-1:0] flag,
   output logic [DATA_W-1:0] rdata
);
   import rtc_irq_pkg::*;
   always_comb begin
      case (acc_sel_e'(sel))
         SEL_CTL:  rdata = ctl;
         SEL_FLAG: rdata = flag;
         SEL_STAT: rdata = STAT_V;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl #(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  STAT_V   = 8'h80,
   parameter logic [7:0]  CLR_MASK = 8'h68
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        evt_per,
   input  logic        evt_alm,
   input  logic        evt_upd,
   input  logic        acc_en,
   input  logic        acc_wr,
   input  logic [1:0]  acc_sel,
   input  logic [7:0]  acc_wdata,
   output logic [7:0]  acc_rdata,
   output logic        irq
);
   import rtc_irq_pkg::*;

   localparam int FLAG_MSB = FLAG_LSB + SRC_N - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("rtc_irq_ctl: DATA_W must be 8");
   end
   if (FLAG_MSB >= SUM_BIT) begin : g_bad_layout
      $error("rtc_irq_ctl: flag field overlaps summary bit");
   end

   logic [SRC_N-1:0] ev, en_now, flags;
   logic             sum, ctl_wr, flag_rd;
   logic [7:0]       ctl_q, flag_q;

   assign ev      = {evt_per, evt_alm, evt_upd};
   assign ctl_wr  = acc_en &  acc_wr & (acc_sel == SEL_CTL);
   assign flag_rd = acc_en & ~acc_wr & (acc_sel == SEL_FLAG);
   assign en_now  = ctl_wr ? acc_wdata[FLAG_MSB:FLAG_LSB] : ctl_q[FLAG_MSB:FLAG_LSB];

   rtc_ctl_reg #(.DATA_W(8), .CLR_MASK(CLR_MASK)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(acc_wdata), .q(ctl_q)
   );

   rtc_flag_bank #(.SRC_N(SRC_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(flag_rd), .reeval(ctl_wr),
      .en_now(en_now), .flags(flags), .sum(sum)
   );

   always_comb begin
      flag_q                    = '0;
      flag_q[FLAG_MSB:FLAG_LSB] = flags;
      flag_q[SUM_BIT]           = sum;
   end

   rtc_rd_mux #(.DATA_W(8), .STAT_V(STAT_V)) u_rd (
      .sel(acc_sel), .ctl(ctl_q), .flag(flag_q), .rdata(acc_rdata)
   );

   assign irq = sum;
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_en,
   input logic       acc_wr,
   input logic [1:0] acc_sel,
   input logic [7:0] acc_wdata,
   input logic       evt_per,
   input logic       evt_alm,
   input logic       evt_upd,
   input logic [7:0] ctl_q,
   input logic [7:0] flag_q,
   input logic       irq
);
   logic [2:0] ev;
   logic       rd_c, wr_b, wr_other;
   assign ev       = {evt_per, evt_alm, evt_upd};
   assign rd_c     = acc_en && !acc_wr && acc_sel == 2'd1;
   assign wr_b     = acc_en && acc_wr && acc_sel == 2'd0;
   assign wr_other = acc_en && acc_wr && acc_sel != 2'd0;

   // R1
   per_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_per |=> flag_q[6]);
   // R2
   new_flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && |(ev & ctl_q[6:4] & ~flag_q[6:4])) |=> irq);
   // R3
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c && ev == 3'b000) |=> (!irq && flag_q == 8'h00));
   // R4
   read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c && evt_alm) |=> flag_q[5]);
   // R5
   wr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && |(acc_wdata[6:4] & flag_q[6:4])) |=> irq);
   // R5
   wr_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && ev == 3'b000 && !(|(acc_wdata[6:4] & flag_q[6:4]))) |=> !irq);
   // R6
   wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_other |=> $stable(ctl_q));
   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !acc_en) |=> irq);
endmodule

bind rtc_irq_ctl rtc_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
   .acc_sel(acc_sel), .acc_wdata(acc_wdata), .evt_per(evt_per),
   .evt_alm(evt_alm), .evt_upd(evt_upd), .ctl_q(ctl_q), .flag_q(flag_q),
   .irq(irq)
);

// File: tb/tb_rtc_irq_ctl.sv
module tb_rtc_irq_ctl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_per = 0, evt_alm = 0, evt_upd = 0;
   logic       acc_en = 0, acc_wr = 0;
   logic [1:0] acc_sel = 0;
   logic [7:0] acc_wdata = 0;
   logic [7:0] acc_rdata;
   logic       irq;

   int tests = 0, fails = 0;
   bit done = 0;

   logic [7:0] m_b = 8'h00;
   logic [2:0] m_fl = 3'b000;
   logic       m_sum = 1'b0;

   rtc_irq_ctl dut (
      .clk(clk), .rst_n(rst_n), .evt_per(evt_per), .evt_alm(evt_alm),
      .evt_upd(evt_upd), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] exp_rd(input logic [1:0] sel);
      case (sel)
         2'd0:    return m_b;
         2'd1:    return {m_sum, m_fl, 4'b0000};
         2'd2:    return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] ev, input logic en, input logic wr,
                       input logic [1:0] sel, input logic [7:0] d, input string tag);
      logic clr, wb;
      logic [2:0] base, fresh, fl_n, enn;
      @(negedge clk);
      {evt_per, evt_alm, evt_upd} = ev;
      acc_en = en; acc_wr = wr; acc_sel = sel; acc_wdata = d;
      #1;
      if (en && !wr) chk({tag, " read"}, acc_rdata, exp_rd(sel));
      clr   = en && !wr && sel == 2'd1;
      wb    = en && wr && sel == 2'd0;
      base  = clr ? 3'b000 : m_fl;
      fresh = ev & ~base;
      fl_n  = base | ev;
      enn   = wb ? d[6:4] : m_b[6:4];
      m_sum = wb ? |(enn & fl_n) : ((clr ? 1'b0 : m_sum) | |(fresh & enn));
      m_fl  = fl_n;
      if (wb) m_b = d;
      @(posedge clk);
      #1;
      {evt_per, evt_alm, evt_upd} = 3'b000;
      acc_en = 0;
      chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_sum});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      @(posedge clk);
      #1;
      m_b = m_b & ~8'h68; m_fl = 0; m_sum = 0;
      // R7
      chk("R7 irq low in reset", {7'b0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      do_reset();
      step(3'b000, 1, 1, 2'd0, 8'h00, "R9 init ctl");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R7 status zero after reset");
      step(3'b000, 1, 0, 2'd2, 8'h00, "R6 fixed byte");
      // R1: events with enables off set flags, no irq
      step(3'b100, 0, 0, 2'd0, 8'h00, "R1 per no enable");
      step(3'b011, 0, 0, 2'd0, 8'h00, "R1 alm upd no enable");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R1 flags readable");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R3 cleared after read");
      // R2: enable alarm then event
      step(3'b000, 1, 1, 2'd0, 8'h20, "R9 enable alarm");
      step(3'b010, 0, 0, 2'd0, 8'h00, "R2 alarm raises irq");
      step(3'b000, 0, 0, 2'd0, 8'h00, "R8 irq holds");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R3 read clears irq");
      // R2: event on flag already set
      step(3'b001, 0, 0, 2'd0, 8'h00, "R2 upd disabled");
      step(3'b000, 1, 1, 2'd0, 8'h00, "R5 write no match lowers");
      step(3'b000, 1, 1, 2'd0, 8'h10, "R5 enable meets pending flag");
      step(3'b000, 1, 1, 2'd0, 8'h40, "R5 remove match lowers");
      step(3'b001, 0, 0, 2'd0, 8'h00, "R2 repeat on set flag no irq");
      // R4: event during read
      step(3'b000, 1, 1, 2'd0, 8'h40, "R9 enable periodic");
      step(3'b100, 1, 0, 2'd1, 8'h00, "R4 event during read");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R4 flag kept");
      // R6: writes to status/fixed/unused ignored
      step(3'b000, 1, 1, 2'd1, 8'hFF, "R6 write status");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R6 status unchanged");
      step(3'b000, 1, 1, 2'd2, 8'h00, "R6 write fixed");
      step(3'b000, 1, 0, 2'd2, 8'h00, "R6 fixed unchanged");
      step(3'b000, 1, 1, 2'd3, 8'h55, "R9 write unused");
      step(3'b000, 1, 0, 2'd3, 8'h00, "R9 unused reads zero");
      step(3'b000, 1, 0, 2'd0, 8'h00, "R9 ctl unchanged");
      // R7: partial reset of control byte
      step(3'b000, 1, 1, 2'd0, 8'hFF, "R9 ctl all ones");
      step(3'b111, 0, 0, 2'd0, 8'h00, "R2 all events");
      do_reset();
      step(3'b000, 1, 0, 2'd0, 8'h00, "R7 ctl after reset");
      step(3'b000, 1, 0, 2'd1, 8'h00, "R7 status after reset");
      // random phase
      void'($urandom(32'd1234));
      for (int i = 0; i < 600; i++) begin
         logic [2:0] ev;
         logic en, wr;
         logic [1:0] sel;
         logic [7:0] d;
         ev  = {($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 4 == 0)};
         en  = ($urandom % 2) == 1;
         wr  = ($urandom % 3) == 0;
         sel = 2'($urandom % 4);
         d   = 8'($urandom);
         step(ev, en, wr, sel, d, "R2 R3 R5 R8 random");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule